// File: doc/BRIEF.md
# Serial ROM to Control-Store Bootstrap Loader

This block fills a set of byte-wide control-store RAMs from a serial flash ROM when the machine comes out of reset. It opens the ROM with a standard read command at address zero. It then streams the ROM contents one bit per SCK period and gathers them into a byte. Each completed byte is written into the control store. The byte index runs linearly: its low bits address a location inside one RAM, and its high bits choose which RAM receives the write. Each RAM is filled with exactly 1 KB before the loader moves to the next one, and the RAMs are filled in ascending order.

The RAM data pins are also the live control lines of the CPU. The loader therefore holds a control-drive output high for the whole copy. That output disables the isolation buffer between the RAM data pins and the rest of the machine, and it also gates off any decoder that could drive a shared bus. When the last byte is written, the loader releases the ROM, drops control-drive and raises a done flag. From then on the RAMs drive the control lines in the normal way.

Top module: `ucode_boot_copier`

## Requirements
- R1: While `rst_ni` is low: `spi_cs_no`=1, `spi_sck_o`=0, `ram_we_no`=1, every bit of `ram_cs_no`=1, `ctrl_drv_o`=1 and `done_o`=0.
- R2: On the first clock after reset, `spi_cs_no` goes low and stays low until the copy ends. MOSI carries 32 bits, MSB first: the read command 0x03 followed by 24 zero address bits. Each bit is presented for one full SCK period, starting with SCK low.
- R3: While bits are moving, SCK is low for one clock and then high for one clock. MOSI changes only at the edge where SCK falls. SCK is low whenever the ROM is deselected.
- R4: After the 32 header bits, MISO is taken as data, MSB first. A bit is captured when SCK falls, so the value held during the high phase is the one used. Eight bits form one byte, and that byte appears on `ram_data_o`.
- R5: After the eighth bit of a byte there is one setup clock, followed by exactly one clock with `ram_we_no` low. SCK stays low through both clocks. `ram_addr_o` and `ram_data_o` keep the same value from the setup clock through the write clock. Bit streaming resumes on the next clock.
- R6: For byte n (counting from 0), `ram_addr_o` = n mod 1024 and the RAM written is n / 1024. During the write clock exactly one bit of `ram_cs_no` is low: bit n / 1024. The address advances by one after each write.
- R7: A `ram_cs_no` bit is low only during a write clock. Each of the 6 RAMs receives exactly 1024 writes, in order from RAM 0 to RAM 5.
- R8: After byte 6143 has been written, the following hold permanently: `spi_cs_no`=1, SCK low, `ram_we_no`=1, `done_o`=1 and `ctrl_drv_o`=0.
- R9: `ctrl_drv_o` stays high from reset until the copy is complete.
- R10: If reset is asserted in the middle of a copy, the reset state of R1 is restored. After reset is released, the copy starts again from the read command and from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; restarts the copy |
| spi_miso_i | input | 1 | Serial data from the ROM |
| spi_cs_no | output | 1 | ROM select, active low |
| spi_sck_o | output | 1 | Serial clock to the ROM (half the system clock rate) |
| spi_mosi_o | output | 1 | Command and address bits to the ROM |
| ram_addr_o | output | 10 | Address inside the selected RAM |
| ram_data_o | output | 8 | Assembled byte for the RAM data pins |
| ram_we_no | output | 1 | RAM write strobe, active low, one clock per byte |
| ram_cs_no | output | 6 | Per-RAM select, active low, low only during a write |
| ctrl_drv_o | output | 1 | High while loading: isolates the RAM data pins and gates off bus-driving decoders |
| done_o | output | 1 | High once all RAMs are filled |

## Verification
The bench goes after the cases where the copy moves from one region to the next. The first is the step from the 32-bit header into the first data bit. A design that miscounts this step shifts every byte by one bit and writes rotated data. The second is the 1 KB boundary, where a wrong decode selects two RAMs, or selects the wrong one, and overwrites a region that was already loaded. The bench also checks the setup and strobe clocks, where a design that lets SCK run or the address move under the strobe would write garbage. It covers the final byte, where a design that stops early or late leaves a RAM short, or keeps control-drive asserted. Finally, a reset in the middle of RAM 1 must restart the copy from the command and not resume at the old address.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    S_RST,
    S_HDR,
    S_DATA,
    S_STAGE,
    S_WRITE,
    S_DONE
  } ld_state_e;
endpackage

// File: rtl/spi_serdes.sv
module spi_serdes #(
  parameter int FRAME_W = 32,
  parameter int DW      = 8,
  parameter logic [FRAME_W-1:0] FRAME = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          bit_end_o,
  output logic [DW-1:0] rx_o
);
  logic               sck_q;
  logic [FRAME_W-1:0] tx_q;
  logic [DW-1:0]      rx_q;

  // a bit ends at the edge where sck falls
  assign bit_end_o = run_i & sck_q;
  assign sck_o     = sck_q;
  assign mosi_o    = tx_q[FRAME_W-1];
  assign rx_o      = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else if (start_i) begin
      sck_q <= 1'b0;
      tx_q  <= FRAME;
    end else if (run_i) begin
      sck_q <= ~sck_q;
      if (sck_q) begin
        tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        rx_q <= {rx_q[DW-2:0], miso_i};
      end
    end else begin
      sck_q <= 1'b0;
    end
  end

  // R4: byte is held while streaming is paused
  a_r4_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(rx_o));
  // R3: sck parks low when not streaming
  a_r3_sck_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !sck_o) |=> !sck_o);
endmodule

// File: rtl/copy_counter.sv
module copy_counter #(
  parameter int HDR_BITS = 32,
  parameter int DW       = 8,
  parameter int RAM_AW   = 10,
  parameter int NUM_RAMS = 6,
  localparam int BC_W    = $clog2(HDR_BITS),
  localparam int CHIP_W  = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1,
  localparam int IDX_W   = RAM_AW + CHIP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hdr_i,
  input  logic              bit_end_i,
  input  logic              byte_adv_i,
  output logic              last_bit_o,
  output logic              last_byte_o,
  output logic [RAM_AW-1:0] addr_o,
  output logic [CHIP_W-1:0] chip_o
);
  localparam int TOTAL = NUM_RAMS << RAM_AW;

  logic [BC_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [BC_W-1:0]  bit_lim;

  assign bit_lim     = hdr_i ? BC_W'(HDR_BITS - 1) : BC_W'(DW - 1);
  assign last_bit_o  = bit_end_i && (bit_cnt_q == bit_lim);
  assign last_byte_o = (idx_q == IDX_W'(TOTAL - 1));
  assign addr_o      = idx_q[RAM_AW-1:0];
  assign chip_o      = idx_q[IDX_W-1:RAM_AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      idx_q     <= '0;
    end else if (clr_i) begin
      bit_cnt_q <= '0;
      idx_q     <= '0;
    end else begin
      if (last_bit_o)     bit_cnt_q <= '0;
      else if (bit_end_i) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (byte_adv_i)     idx_q     <= idx_q + 1'b1;
    end
  end

  // R6: byte index only moves one step at a time
  a_r6_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_adv_i && !clr_i) |=> addr_o == RAM_AW'($past(addr_o) + 1'b1));
endmodule

// File: rtl/chip_decode.sv
module chip_decode #(
  parameter int NUM_RAMS = 6,
  localparam int CHIP_W  = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1
) (
  input  logic                en_i,
  input  logic [CHIP_W-1:0]   chip_i,
  output logic [NUM_RAMS-1:0] cs_no
);
  for (genvar g = 0; g < NUM_RAMS; g++) begin : g_cs
    assign cs_no[g] = !(en_i && (chip_i == CHIP_W'(g)));
  end
endmodule

// File: rtl/ucode_boot_copier.sv
module ucode_boot_copier
  import boot_pkg::*;
#(
  parameter int          NUM_RAMS = 6,
  parameter int          RAM_AW   = 10,
  parameter int          DW       = 8,
  parameter int          ADDR_W   = 24,
  parameter logic [7:0]  RD_CMD   = 8'h03
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                spi_miso_i,
  output logic                spi_cs_no,
  output logic                spi_sck_o,
  output logic                spi_mosi_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic [DW-1:0]       ram_data_o,
  output logic                ram_we_no,
  output logic [NUM_RAMS-1:0] ram_cs_no,
  output logic                ctrl_drv_o,
  output logic                done_o
);
  localparam int HDR_BITS = 8 + ADDR_W;
  localparam int CHIP_W   = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1;
  localparam logic [HDR_BITS-1:0] FRAME = {RD_CMD, {ADDR_W{1'b0}}};

  ld_state_e        state_q, state_d;
  logic             start, run, bit_end, last_bit, last_byte, wr;
  logic [CHIP_W-1:0] chip;

  assign start = (state_q == S_RST);
  assign run   = (state_q == S_HDR) || (state_q == S_DATA);
  assign wr    = (state_q == S_WRITE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RST:   state_d = S_HDR;
      S_HDR:   if (last_bit) state_d = S_DATA;
      S_DATA:  if (last_bit) state_d = S_STAGE;
      S_STAGE: state_d = S_WRITE;
      S_WRITE: state_d = last_byte ? S_DONE : S_DATA;
      S_DONE:  state_d = S_DONE;
      default: state_d = S_RST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_RST;
    else         state_q <= state_d;
  end

  spi_serdes #(.FRAME_W(HDR_BITS), .DW(DW), .FRAME(FRAME)) u_serdes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (run),
    .miso_i    (spi_miso_i),
    .sck_o     (spi_sck_o),
    .mosi_o    (spi_mosi_o),
    .bit_end_o (bit_end),
    .rx_o      (ram_data_o)
  );

  copy_counter #(.HDR_BITS(HDR_BITS), .DW(DW), .RAM_AW(RAM_AW), .NUM_RAMS(NUM_RAMS)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start),
    .hdr_i       (state_q == S_HDR),
    .bit_end_i   (bit_end),
    .byte_adv_i  (wr),
    .last_bit_o  (last_bit),
    .last_byte_o (last_byte),
    .addr_o      (ram_addr_o),
    .chip_o      (chip)
  );

  chip_decode #(.NUM_RAMS(NUM_RAMS)) u_dec (
    .en_i   (wr),
    .chip_i (chip),
    .cs_no  (ram_cs_no)
  );

  assign spi_cs_no  = (state_q == S_RST) || (state_q == S_DONE);
  assign ram_we_no  = !wr;
  assign done_o     = (state_q == S_DONE);
  assign ctrl_drv_o = (state_q != S_DONE);

  // R5: strobe lasts a single clock
  a_r5_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |=> ram_we_no);
  // R5: address and data settled before the strobe
  a_r5_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> ($stable(ram_addr_o) && $stable(ram_data_o) && !spi_sck_o));
  // R6: one RAM selected per write
  a_r6_one_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> ($countones(~ram_cs_no) == 1));
  // R7: no select outside a write clock
  a_r7_cs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_no |-> (&ram_cs_no));
  // R8: finished loader stays quiet
  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (spi_cs_no && !spi_sck_o && ram_we_no && !ctrl_drv_o));
  // R3: sck idle while ROM deselected
  a_r3_sck_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  // R9: isolation released only together with done
  a_r9_drv_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_drv_o) |-> ($rose(done_o) && $past(!ram_we_no)));
endmodule

// File: tb/sim_ucode_boot_copier.sv
module sim_ucode_boot_copier;
  localparam int CLK_PERIOD = 10;
  localparam int NR    = 6;
  localparam int AW    = 10;
  localparam int TOTAL = NR << AW;
  localparam int TD    = 65 + 18 * TOTAL;
  localparam logic [31:0] HDR = 32'h0300_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic miso = 1'b0;
  logic spi_cs_n, sck, mosi, we_n, drv, done;
  logic [AW-1:0] addr;
  logic [7:0] data;
  logic [NR-1:0] ram_cs_n;

  int checks = 0;
  int errors = 0;
  int t = 0;
  int nfall = 0;
  logic prev_sck = 1'b0;
  int wr_cnt [NR];
  string rst_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_boot_copier u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_miso_i(miso),
    .spi_cs_no(spi_cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi),
    .ram_addr_o(addr), .ram_data_o(data), .ram_we_no(we_n),
    .ram_cs_no(ram_cs_n), .ctrl_drv_o(drv), .done_o(done)
  );

  function automatic logic [7:0] byte_val(int i);
    return 8'((i * 37) + (i >> 7) + 5);
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s t=%0d act=%0h exp=%0h", req, what, t, act, exp);
    end
  endtask

  // behavioural expectation for cycle t
  task automatic check_cycle();
    int e_cs, e_sck, e_we, e_drv, e_done, e_mosi, chip, ea, ed, u, b, r;
    logic [NR-1:0] e_rcs;
    string tg;
    e_mosi = -1; chip = -1; ea = -1; ed = -1;
    e_drv = 1; e_done = 0; e_we = 1; e_sck = 0; e_cs = 0;
    if (t == 0) begin
      e_cs = 1; tg = rst_tag;
    end else if (t <= 64) begin
      tg = "R2";
      e_sck  = (t - 1) % 2;
      e_mosi = int'(HDR[31 - (t - 1) / 2]);
    end else if (t < TD) begin
      tg = "R5";
      u = t - 65; b = u / 18; r = u % 18;
      e_mosi = 0;
      e_sck = (r < 16) ? r % 2 : 0;
      if (r >= 16) begin ea = b % 1024; ed = int'(byte_val(b)); end
      if (r == 17) begin e_we = 0; chip = b / 1024; end
    end else begin
      tg = "R8";
      e_cs = 1; e_drv = 0; e_done = 1;
    end
    e_rcs = (chip >= 0) ? ~(NR'(1) << chip) : '1;
    chk(int'(spi_cs_n) == e_cs, (t > 0 && t < TD) ? "R2" : tg, "spi_cs_n", int'(spi_cs_n), e_cs);
    chk(int'(sck) == e_sck, (t > 0 && t < TD) ? "R3" : tg, "sck", int'(sck), e_sck);
    chk(int'(we_n) == e_we, tg, "we_n", int'(we_n), e_we);
    chk(ram_cs_n == e_rcs, (chip >= 0) ? "R6" : ((t == 0) ? tg : "R7"), "ram_cs_n", int'(ram_cs_n), int'(e_rcs));
    chk(int'(drv) == e_drv, (t == 0) ? tg : ((t < TD) ? "R9" : "R8"), "ctrl_drv", int'(drv), e_drv);
    chk(int'(done) == e_done, (t == 0) ? tg : "R8", "done", int'(done), e_done);
    if (e_mosi >= 0) chk(int'(mosi) == e_mosi, "R2", "mosi", int'(mosi), e_mosi);
    if (ea >= 0) begin
      chk(int'(addr) == ea, "R6", "addr", int'(addr), ea);
      chk(int'(data) == ed, "R4", "data", int'(data), ed);
    end
    if (!we_n) begin
      for (int k = 0; k < NR; k++) if (!ram_cs_n[k]) wr_cnt[k]++;
    end
  endtask

  // ROM: present data bit after each falling sck once the header is done
  task automatic rom_update();
    int d;
    if (spi_cs_n) begin
      nfall = 0; miso = 1'b0;
    end else begin
      if (prev_sck && !sck) nfall++;
      if (nfall >= 32) begin
        d = nfall - 32;
        miso = byte_val(d / 8)[7 - (d % 8)];
      end
    end
    prev_sck = sck;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) t++;
    @(negedge clk);
    check_cycle();
    rom_update();
    if (errors > 40) summary();
  endtask

  initial begin
    for (int k = 0; k < NR; k++) wr_cnt[k] = 0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    check_cycle();           // R1 reset state
    rom_update();
    repeat (3) step();
    rst_n = 1'b1;
    // first copy, interrupted inside RAM 1
    while (t < 65 + 18 * 1030 + 7) step();
    rst_n = 1'b0;
    #1;
    t = 0;
    rst_tag = "R10";
    check_cycle();           // R10 reset mid-copy
    for (int k = 0; k < NR; k++) wr_cnt[k] = 0;
    repeat (2) step();
    rst_n = 1'b1;
    while (t < TD + 12) step();
    for (int k = 0; k < NR; k++)
      chk(wr_cnt[k] == 1024, "R7", $sformatf("writes to ram %0d", k), wr_cnt[k], 1024);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog t=%0d act=running exp=finished", t);
    summary();
  end
endmodule